// File: doc/BRIEF.md
# Serial DAC Input Register and Code Latch

This block is the digital front end of a serially loaded DAC. A host writes a 16-bit word over a three-wire link: an active-low chip select, a serial clock and a data line. The word enters most significant bit first, one bit on each rising serial clock edge. The rising edge of chip select then copies it into a parallel code latch. The converter resolution is a parameter of 12, 14 or 16 bits. The code always comes from the top of the word, and the unused low bits are ignored.

All three link pins are asynchronous to the block. Each one passes through a two-flop synchronizer and then edge detection in the system clock domain. A frame that carries fewer than 16 clock edges is rejected: the latch keeps its value and an error pulse is raised. If a frame carries more than 16 edges, the most recent 16 bits are used. Each accepted frame gives a one-cycle update strobe in the same cycle that the new code appears.

Top module: `sdac_front`

## Requirements
- R1: After reset, code_o is zero and update_o and frame_err_o are low. The block then waits for a chip select falling edge.
- R2: While cs_n_i is low, each rising edge of sclk_i shifts din_i into the word, MSB first. A rising edge of cs_n_i after exactly 16 edges loads word bits [15:16-RES_W] into code_o, right-aligned.
- R3: Each accepted frame raises update_o for exactly one system clock cycle. code_o changes only in a cycle in which update_o is high.
- R4: When a frame carries more than 16 rising sclk_i edges, only the last 16 bits received reach the latch.
- R5: When a frame carries fewer than 16 rising sclk_i edges, including none, code_o is left unchanged and frame_err_o pulses high for one cycle. update_o and frame_err_o are never high together.
- R6: While cs_n_i is high, activity on sclk_i and din_i changes no output.
- R7: With RES_W below 16, the trailing 16-RES_W bits of the word are don't-care. Two words that differ only there give the same code_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select; frames a transfer |
| sclk_i | input | 1 | Serial clock; data is sampled on its rising edge |
| din_i | input | 1 | Serial data in, MSB first |
| code_o | output | RES_W | Latched DAC code, right-aligned |
| update_o | output | 1 | One-cycle strobe when a new code is latched |
| frame_err_o | output | 1 | One-cycle pulse when a short frame is rejected |

## Verification
The assertions assume well-behaved link timing. Every high and low phase of sclk_i lasts at least two system clocks. din_i is stable across each rising sclk_i edge. Edges on cs_n_i are at least two system clocks away from any sclk_i edge. Because of this, successive strobes are always separated by idle cycles. The bench holds each serial clock phase for four system clocks and changes data only while the serial clock is low. It also leaves a four-cycle gap between a chip select edge and the first or last serial clock edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic lvl;
    logic rise;
    logic fall;
  } pin_evt_t;
endpackage

// File: rtl/sdac_sync_edge.sv
module sdac_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               d_i,
  output sdac_pkg::pin_evt_t evt_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {(STAGES+1){RST_VAL}};
    else         chain_q <= {chain_q[STAGES-1:0], d_i};
  end

  always_comb begin
    evt_o.lvl  = chain_q[STAGES-1];
    evt_o.rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    evt_o.fall = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
  import sdac_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               shift_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] word_o,
  output logic               full_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      word_o <= {word_o[FRAME_W-2:0], bit_i};
      if (cnt_q != CNT_W'(FRAME_W)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign full_o = (cnt_q == CNT_W'(FRAME_W));
endmodule

// File: rtl/sdac_latch.sv
module sdac_latch
  import sdac_pkg::*;
#(
  parameter int RES_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               full_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [RES_W-1:0]   code_o,
  output logic               update_o,
  output logic               err_o
);
  localparam int LSB = FRAME_W - RES_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o   <= '0;
      update_o <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      update_o <= load_i & full_i;
      err_o    <= load_i & ~full_i;
      if (load_i && full_i) code_o <= word_i[FRAME_W-1:LSB];
    end
  end
endmodule

// File: rtl/sdac_front.sv
module sdac_front
  import sdac_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             sclk_i,
  input  logic             din_i,
  output logic [RES_W-1:0] code_o,
  output logic             update_o,
  output logic             frame_err_o
);
  localparam int NPIN = 3;
  localparam logic [NPIN-1:0] IDLE_PAT = 3'b001;  // {din, sclk, cs_n}

  logic [NPIN-1:0] pins;
  pin_evt_t        evt [NPIN];
  logic [FRAME_W-1:0] word;
  logic               full;

  assign pins = {din_i, sclk_i, cs_n_i};

  for (genvar i = 0; i < NPIN; i++) begin : g_sync
    sdac_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(IDLE_PAT[i])) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pins[i]),
      .evt_o (evt[i])
    );
  end

  sdac_shift u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(evt[0].fall),
    .shift_i(evt[1].rise & ~evt[0].lvl),
    .bit_i  (evt[2].lvl),
    .word_o (word),
    .full_o (full)
  );

  sdac_latch #(.RES_W(RES_W)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (evt[0].rise),
    .full_i  (full),
    .word_i  (word),
    .code_o  (code_o),
    .update_o(update_o),
    .err_o   (frame_err_o)
  );
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int RES_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic [RES_W-1:0] code_o,
  input logic             update_o,
  input logic             frame_err_o
);
  a_r3_code_moves_with_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> update_o);
  a_r3_update_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);
  a_r5_err_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
  a_r5_err_keeps_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> $stable(code_o));
  a_r5_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(update_o && frame_err_o));
  a_r6_pulse_needs_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (update_o || frame_err_o) |-> cs_n_i);
endmodule

bind sdac_front sdac_front_chk #(.RES_W(RES_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .code_o     (code_o),
  .update_o   (update_o),
  .frame_err_o(frame_err_o)
);

// File: tb/tb_sdac_front.sv
`timescale 1ns/1ps
module tb_sdac_front;
  localparam int RES_W = 12;
  localparam int HALF  = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [RES_W-1:0] code;
  logic upd, ferr;

  int n_tests = 0, n_fail = 0;
  int upd_cnt = 0, err_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdac_front #(.RES_W(RES_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .code_o(code), .update_o(upd), .frame_err_o(ferr)
  );

  // behavioural reference: pin history queue, bit list per frame
  logic [2:0] hist[$];
  bit         bits[$];
  logic [RES_W-1:0] m_code;
  logic m_upd, m_err;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist = {3'b001, 3'b001, 3'b001};
      bits.delete();
      m_code = '0; m_upd = 0; m_err = 0;
    end else begin
      logic [2:0] nw, od;
      hist.push_back({din, sclk, cs_n});
      nw = hist[hist.size()-3];
      od = hist[hist.size()-4];
      void'(hist.pop_front());
      m_upd = 0; m_err = 0;
      if (od[0] && !nw[0]) bits.delete();
      else if (!od[0] && nw[0]) begin
        if (bits.size() >= 16) begin
          logic [15:0] w;
          for (int i = 0; i < 16; i++) w[i] = bits[bits.size()-1-i];
          m_code = w[15 -: RES_W];
          m_upd  = 1;
        end else m_err = 1;
      end else if (!nw[0] && !od[1] && nw[1]) bits.push_back(nw[2]);
    end
  end

  always @(negedge clk) if (rst_ni && !done) begin
    n_tests++;
    if (code !== m_code || upd !== m_upd || ferr !== m_err) begin
      n_fail++;
      $display("FAIL R3 model: code=%h upd=%b err=%b expected code=%h upd=%b err=%b",
               code, upd, ferr, m_code, m_upd, m_err);
    end
    if (upd) upd_cnt++;
    if (ferr) err_cnt++;
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [31:0] w, int n);
    @(negedge clk); cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      din = w[i];
      wait_clk(HALF); sclk = 1'b1;
      wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(HALF); cs_n = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    #(200000 * 10);
    $display("FAIL watchdog: actual=timeout expected=finish");
    n_tests++; n_fail++;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int u0, e0;
    wait_clk(3);
    check("R1 code", 32'(code), 0);
    check("R1 upd", 32'(upd), 0);
    check("R1 err", 32'(ferr), 0);
    @(negedge clk); rst_ni = 1'b1;
    wait_clk(5);
    check("R1 idle code", 32'(code), 0);

    u0 = upd_cnt; e0 = err_cnt;
    send(32'h0000_A5C3, 16);
    check("R2 full frame", 32'(code), 32'h0A5C);
    check("R3 one strobe", 32'(upd_cnt - u0), 1);

    u0 = upd_cnt;
    send(32'h0000_A5CF, 16);
    check("R7 dont-care low bits", 32'(code), 32'h0A5C);
    check("R7 strobe", 32'(upd_cnt - u0), 1);

    send(32'h0007_1234, 20);
    check("R4 last 16 bits", 32'(code), 32'h0123);

    u0 = upd_cnt; e0 = err_cnt;
    send(32'h0000_03FF, 10);
    check("R5 short keeps code", 32'(code), 32'h0123);
    check("R5 err pulse", 32'(err_cnt - e0), 1);
    check("R5 no strobe", 32'(upd_cnt - u0), 0);

    e0 = err_cnt;
    send(32'h0, 0);
    check("R5 empty frame err", 32'(err_cnt - e0), 1);

    u0 = upd_cnt; e0 = err_cnt;
    for (int i = 0; i < 6; i++) begin
      din = i[0]; wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(10);
    check("R6 cs high code", 32'(code), 32'h0123);
    check("R6 cs high pulses", 32'(upd_cnt - u0 + err_cnt - e0), 0);

    send(32'h0000_FFFF, 16);
    check("R2 all ones", 32'(code), 32'h0FFF);
    send(32'h0000_000F, 16);
    check("R7 zero code", 32'(code), 32'h0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule